// File: doc/BRIEF.md
# Command-Stream Video Register Bank

This block sits at the receiving end of a byte-wide command stream and turns register-write commands into updates of a bank of video configuration bytes. Each command opens with a marker byte of value 0xAF and then carries a code byte. Code 0x20 is a register write, and an address byte and a data byte follow it. Every write lands in a shadow copy of the bank. The active copy drives the downstream timing generator. It changes only when a write to the lock address closes a lock/unlock pair, so a whole mode change reaches the display in one step.

Other command codes, such as bulk pixel copies, belong to other units. The parser skips their payload until the next marker byte. A byte that arrives where a marker is expected and is not 0xAF is dropped and raises a one-cycle error pulse. The input is always ready. The bank decodes the active bytes into named fields: colour depth, two framebuffer base pointers, twelve 16-bit timing fields, the pixel clock and the blanking mode.

The parser is a five-state machine:
- `ST_PREFIX` waits for a marker. 0xAF moves to `ST_CODE`. Any other byte raises an error and stays in `ST_PREFIX`.
- `ST_CODE` moves to `ST_ADDR` on 0x20 and to `ST_SKIP` on any other code.
- `ST_ADDR` latches the address and moves to `ST_VALUE`.
- `ST_VALUE` issues the write and returns to `ST_PREFIX`.
- `ST_SKIP` discards bytes and moves to `ST_CODE` on 0xAF.

Top module: `vid_cmd_regbank`

## Requirements
- R1: After reset, every decoded field output is zero, `err_pulse` is 0, the bank is unlocked and `in_ready` is 1.
- R2: A write command (0xAF, 0x20, address, value) stores the value in the shadow byte at that address. The active fields do not change until a commit.
- R3: Writing 0xFF to address 0xFF while the bank is locked copies every shadow byte into the active bank. The new values appear right after the clock edge that accepts the value byte, and the bank becomes unlocked.
- R4: Writing 0x00 to address 0xFF locks the bank. An unlock write while unlocked, or any other value written to 0xFF, leaves the active fields and the lock state unchanged.
- R5: Bit 0 of the byte at address 0x00 drives `depth24`: 0 selects 16 bpp and 1 selects 24 bpp.
- R6: `fb16_base` is formed from the bytes at 0x20, 0x21 and 0x22, and `fb8_base` from the bytes at 0x26, 0x27 and 0x28. In both, the lowest address is the most significant byte.
- R7: Each 16-bit timing field at odd address A is {byte A, byte A+1}, high byte first. The fields and their addresses are: h_disp_start 0x01, h_disp_end 0x03, v_disp_start 0x05, v_disp_end 0x07, h_end_cnt 0x09, hs_start 0x0B, hs_end 0x0D, h_pixels 0x0F, v_end_cnt 0x11, vs_start 0x13, vs_end 0x15 and v_pixels 0x17.
- R8: `pix_clk_5k` is {byte 0x1C, byte 0x1B}: the low byte is at 0x1B and the high byte at 0x1C.
- R9: Bit 0 of the byte at 0x1F drives `power_down`: 0 means display on and 1 means power-down.
- R10: A byte accepted in `ST_PREFIX` that is not 0xAF is dropped and raises `err_pulse` for exactly the next cycle. A following well-formed command is decoded normally.
- R11: A command code other than 0x20 causes all bytes up to the next 0xAF to be skipped. Skipped bytes raise no error and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always 1; a byte is taken on every valid cycle |
| err_pulse | output | 1 | One-cycle pulse after a bad marker byte |
| depth24 | output | 1 | Colour depth select |
| fb16_base | output | 24 | 16 bpp framebuffer base |
| fb8_base | output | 24 | 8 bpp framebuffer base |
| h_disp_start | output | 16 | Horizontal display start |
| h_disp_end | output | 16 | Horizontal display end |
| v_disp_start | output | 16 | Vertical display start |
| v_disp_end | output | 16 | Vertical display end |
| h_end_cnt | output | 16 | Horizontal end count |
| hs_start | output | 16 | Horizontal sync start |
| hs_end | output | 16 | Horizontal sync end |
| h_pixels | output | 16 | Active pixels per line |
| v_end_cnt | output | 16 | Vertical end count |
| vs_start | output | 16 | Vertical sync start |
| vs_end | output | 16 | Vertical sync end |
| v_pixels | output | 16 | Active lines |
| pix_clk_5k | output | 16 | Pixel clock in 5 kHz units |
| power_down | output | 1 | Blanking mode |

## Verification
A commit shows on the field outputs in the cycle right after the edge that accepts the unlock value byte, because only the active-bank register lies on that path. An error pulse is high for exactly the cycle after the edge that accepts the bad byte. The driver presents each byte just after an edge and releases it one nanosecond after the next edge. It pushes expected field values as soon as the relevant byte has been taken. The monitor compares them at the following falling edge, which falls inside the one-cycle window of every result.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
    localparam logic [7:0] CMD_MARK    = 8'hAF;
    localparam logic [7:0] CMD_REGWR   = 8'h20;
    localparam logic [7:0] ADR_LOCK    = 8'hFF;
    localparam logic [7:0] VAL_LOCK    = 8'h00;
    localparam logic [7:0] VAL_UNLOCK  = 8'hFF;

    localparam int ADR_DEPTH   = 8'h00;
    localparam int ADR_FB16    = 8'h20;
    localparam int ADR_FB8     = 8'h26;
    localparam int ADR_TIMING0 = 8'h01;
    localparam int N_TIMING    = 12;
    localparam int ADR_PCLK    = 8'h1B;
    localparam int ADR_BLANK   = 8'h1F;

    typedef enum logic [2:0] {
        ST_PREFIX,
        ST_CODE,
        ST_ADDR,
        ST_VALUE,
        ST_SKIP
    } parse_state_t;
endpackage

// File: rtl/vrb_parser.sv
module vrb_parser
    import vrb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          err_q
);
    parse_state_t state_q, state_d;
    logic [AW-1:0] addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PREFIX;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            unique case (state_q)
                ST_PREFIX: if (in_data == CMD_MARK) state_d = ST_CODE;
                ST_CODE:   state_d = (in_data == CMD_REGWR) ? ST_ADDR : ST_SKIP;
                ST_ADDR:   state_d = ST_VALUE;
                ST_VALUE:  state_d = ST_PREFIX;
                ST_SKIP:   if (in_data == CMD_MARK) state_d = ST_CODE;
                default:   state_d = ST_PREFIX;
            endcase
        end
    end

    // outputs: address latch, error pulse, write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= in_valid && (state_q == ST_PREFIX) && (in_data != CMD_MARK);
            if (in_valid && state_q == ST_ADDR) addr_q <= in_data[AW-1:0];
        end
    end

    assign wr_en   = in_valid && (state_q == ST_VALUE);
    assign wr_addr = addr_q;
    assign wr_data = in_data;

    assert_err_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(in_valid));
    assert_err_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !$past(wr_en));
    assert_skip_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == ST_SKIP) |=> !err_q);
endmodule

// File: rtl/vrb_bank.sv
module vrb_bank
    import vrb_pkg::*;
#(
    parameter int NREG = 64,
    parameter int AW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    output logic [NREG-1:0][7:0] active
);
    logic [NREG-1:0][7:0] shadow;
    logic locked_q;
    logic lock_hit, do_lock, do_commit;

    assign lock_hit  = wr_en && (wr_addr == ADR_LOCK[AW-1:0]);
    assign do_lock   = lock_hit && (wr_data == VAL_LOCK);
    assign do_commit = lock_hit && (wr_data == VAL_UNLOCK) && locked_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         locked_q <= 1'b0;
        else if (do_lock)   locked_q <= 1'b1;
        else if (do_commit) locked_q <= 1'b0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[g] <= '0;
                active[g] <= '0;
            end else begin
                if (wr_en && wr_addr == AW'(g)) shadow[g] <= wr_data;
                if (do_commit) active[g] <= shadow[g];
            end
        end
    end

    assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_commit |=> $stable(active));
    assert_commit_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |=> (active == $past(shadow)));
    assert_commit_clears_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |=> !locked_q);
endmodule

// File: rtl/vrb_fields.sv
module vrb_fields
    import vrb_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic [NREG-1:0][7:0]   active,
    output logic                   depth24,
    output logic [23:0]            fb16_base,
    output logic [23:0]            fb8_base,
    output logic [N_TIMING-1:0][15:0] timing,
    output logic [15:0]            pix_clk_5k,
    output logic                   power_down
);
    assign depth24    = active[ADR_DEPTH][0];
    assign fb16_base  = {active[ADR_FB16], active[ADR_FB16+1], active[ADR_FB16+2]};
    assign fb8_base   = {active[ADR_FB8], active[ADR_FB8+1], active[ADR_FB8+2]};
    assign pix_clk_5k = {active[ADR_PCLK+1], active[ADR_PCLK]};
    assign power_down = active[ADR_BLANK][0];

    for (genvar t = 0; t < N_TIMING; t++) begin : g_tim
        assign timing[t] = {active[ADR_TIMING0 + 2*t], active[ADR_TIMING0 + 2*t + 1]};
    end
endmodule

// File: rtl/vid_cmd_regbank.sv
module vid_cmd_regbank
    import vrb_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        err_pulse,
    output logic        depth24,
    output logic [23:0] fb16_base,
    output logic [23:0] fb8_base,
    output logic [15:0] h_disp_start,
    output logic [15:0] h_disp_end,
    output logic [15:0] v_disp_start,
    output logic [15:0] v_disp_end,
    output logic [15:0] h_end_cnt,
    output logic [15:0] hs_start,
    output logic [15:0] hs_end,
    output logic [15:0] h_pixels,
    output logic [15:0] v_end_cnt,
    output logic [15:0] vs_start,
    output logic [15:0] vs_end,
    output logic [15:0] v_pixels,
    output logic [15:0] pix_clk_5k,
    output logic        power_down
);
    localparam int AW = 8;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [NREG-1:0][7:0] active;
    logic [N_TIMING-1:0][15:0] timing;

    assign in_ready = 1'b1;

    vrb_parser #(.AW(AW)) u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err_q(err_pulse)
    );

    vrb_bank #(.NREG(NREG), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .active(active)
    );

    vrb_fields #(.NREG(NREG)) u_fields (
        .active(active), .depth24(depth24), .fb16_base(fb16_base),
        .fb8_base(fb8_base), .timing(timing), .pix_clk_5k(pix_clk_5k),
        .power_down(power_down)
    );

    assign h_disp_start = timing[0];
    assign h_disp_end   = timing[1];
    assign v_disp_start = timing[2];
    assign v_disp_end   = timing[3];
    assign h_end_cnt    = timing[4];
    assign hs_start     = timing[5];
    assign hs_end       = timing[6];
    assign h_pixels     = timing[7];
    assign v_end_cnt    = timing[8];
    assign vs_start     = timing[9];
    assign vs_end       = timing[10];
    assign v_pixels     = timing[11];
endmodule

// File: tb/sim_vid_cmd_regbank.sv
module sim_vid_cmd_regbank;
    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [7:0] in_data = 0;
    logic in_ready, err_pulse, depth24, power_down;
    logic [23:0] fb16_base, fb8_base;
    logic [15:0] h_disp_start, h_disp_end, v_disp_start, v_disp_end, h_end_cnt,
                 hs_start, hs_end, h_pixels, v_end_cnt, vs_start, vs_end, v_pixels, pix_clk_5k;

    always #5 clk = ~clk;

    vid_cmd_regbank u0 (.*);

    typedef enum int { F_ERR, F_RDY, F_DEPTH, F_FB16, F_FB8, F_HDS, F_HDE, F_HPIX,
                       F_VPIX, F_VSE, F_PCLK, F_PD } fid_t;
    typedef struct { fid_t id; logic [31:0] exp; string req; } item_t;
    item_t q[$];
    int applied = 0, bad = 0;
    bit done = 0;

    function automatic logic [31:0] get(fid_t id);
        case (id)
            F_ERR:   return 32'(err_pulse);
            F_RDY:   return 32'(in_ready);
            F_DEPTH: return 32'(depth24);
            F_FB16:  return 32'(fb16_base);
            F_FB8:   return 32'(fb8_base);
            F_HDS:   return 32'(h_disp_start);
            F_HDE:   return 32'(h_disp_end);
            F_HPIX:  return 32'(h_pixels);
            F_VPIX:  return 32'(v_pixels);
            F_VSE:   return 32'(vs_end);
            F_PCLK:  return 32'(pix_clk_5k);
            default: return 32'(power_down);
        endcase
    endfunction

    task automatic expect_f(fid_t id, logic [31:0] v, string r);
        item_t it;
        it.id = id; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    // monitor
    initial forever begin
        @(negedge clk);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            applied++;
            if (get(it.id) !== it.exp) begin
                bad++;
                $display("FAIL %s field %s: actual %h expected %h", it.req, it.id.name(), get(it.id), it.exp);
            end
        end
    end

    task automatic put(logic [7:0] b);
        in_valid = 1; in_data = b;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] v);
        put(8'hAF); put(8'h20); put(a); put(v);
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle();
        // R1 reset state
        expect_f(F_ERR, 0, "R1"); expect_f(F_RDY, 1, "R1"); expect_f(F_FB16, 0, "R1");
        expect_f(F_HDS, 0, "R1"); expect_f(F_PCLK, 0, "R1"); expect_f(F_PD, 0, "R1");
        idle();

        // lock, load a mode into the shadow
        wr(8'hFF, 8'h00);
        wr(8'h00, 8'h01);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        wr(8'h01, 8'h03); wr(8'h02, 8'h21);
        wr(8'h03, 8'h0A); wr(8'h04, 8'hB0);
        wr(8'h17, 8'h04); wr(8'h18, 8'h38);
        wr(8'h15, 8'h00); wr(8'h16, 8'h05);
        wr(8'h1B, 8'h40); wr(8'h1C, 8'h1F);
        wr(8'h1F, 8'h01);
        // R2 active unchanged before commit
        expect_f(F_DEPTH, 0, "R2"); expect_f(F_FB16, 0, "R2"); expect_f(F_HDS, 0, "R2");
        expect_f(F_PD, 0, "R2");
        wr(8'hFF, 8'hFF);
        // R3 all visible right after the unlock byte
        expect_f(F_FB8, 32'hABCDEF, "R3");
        expect_f(F_DEPTH, 1, "R5");
        expect_f(F_FB16, 32'h123456, "R6"); expect_f(F_FB8, 32'hABCDEF, "R6");
        expect_f(F_HDS, 32'h0321, "R7"); expect_f(F_HDE, 32'h0AB0, "R7");
        expect_f(F_VPIX, 32'h0438, "R7"); expect_f(F_VSE, 32'h0005, "R7");
        expect_f(F_PCLK, 32'h1F40, "R8");
        expect_f(F_PD, 1, "R9");
        idle();

        // R4 unlock while unlocked does nothing
        wr(8'h01, 8'h77);
        wr(8'h1F, 8'h00);
        wr(8'hFF, 8'hFF);
        expect_f(F_HDS, 32'h0321, "R4"); expect_f(F_PD, 1, "R4");
        // lock, other value to 0xFF ignored
        wr(8'hFF, 8'h00);
        wr(8'hFF, 8'h55);
        expect_f(F_HDS, 32'h0321, "R4");
        wr(8'h00, 8'h00);
        wr(8'hFF, 8'hFF);
        expect_f(F_HDS, 32'h7721, "R4"); expect_f(F_PD, 0, "R9"); expect_f(F_DEPTH, 0, "R5");
        idle();

        // R10 bad marker byte
        put(8'h12);
        expect_f(F_ERR, 1, "R10");
        idle();
        expect_f(F_ERR, 0, "R10");
        put(8'hAE);
        expect_f(F_ERR, 1, "R10");
        wr(8'hFF, 8'h00); wr(8'h0F, 8'h05); wr(8'h10, 8'h00); wr(8'hFF, 8'hFF);
        expect_f(F_HPIX, 32'h0500, "R10"); expect_f(F_ERR, 0, "R10");
        idle();

        // R11 skipped command payload
        put(8'hAF); put(8'h6A); put(8'h00); put(8'h00);
        expect_f(F_ERR, 0, "R11");
        put(8'h01); put(8'hFF); put(8'h00);
        expect_f(F_ERR, 0, "R11");
        expect_f(F_HPIX, 32'h0500, "R11"); expect_f(F_HDS, 32'h7721, "R11");
        wr(8'hFF, 8'h00); wr(8'h0F, 8'h07); wr(8'hFF, 8'hFF);
        expect_f(F_HPIX, 32'h0700, "R11"); expect_f(F_ERR, 0, "R11");
        idle();

        done = 1;
        finish_run();
    end
endmodule